// File: doc/BRIEF.md
# Destination-MAC Prefix Forwarding Stage

This block sits in a streaming packet path and chooses the egress port of each Ethernet frame from its destination MAC address. Frames enter as 64-bit stream beats with byte-enable, end-of-frame and error sideband. A metadata word travels with the first beat, and its low bits carry an egress port field. The block stores the whole frame in an internal buffer while it reads the destination address from the first six bytes. It then searches a small programmable table by longest prefix. A hit overwrites the egress port field in the metadata. On a miss the metadata leaves exactly as it arrived. Frames that are too short to hold an Ethernet header, or that carry the error flag on any beat, are discarded from the buffer and never appear at the output.

The table is loaded through a single-cycle write port that gives the entry index, a valid bit, a MAC value, a prefix length and a destination port. Three saturating counters report the number of hit, miss and dropped frames. Frames are handled one at a time: the input stalls from the last beat of a frame until that frame has been dropped or fully sent. A frame must fit in the buffer (FIFO_DEPTH beats), and byte-enables are packed from lane 0 upward.

Top module: `mac_lpm_fwd`

## Requirements
- R1: After reset, m_tvalid is 0, s_tready is 1, all three counters read 0 and every table entry is invalid, so the first frame is a miss.
- R2: The lookup key is the destination MAC taken from the first six bytes of the frame. Byte i of the frame is carried in lane i mod 8 (tdata[8*lane+7:8*lane]) of beat i/8, and frame byte k (k = 0..5) becomes key bits [47-8k:40-8k]. On a hit, m_meta equals s_meta of the first beat with bits [PORT_W-1:0] replaced by the port of the winning entry. All other bits are unchanged.
- R3: On a miss, m_meta equals the s_meta value of the first beat, bit for bit.
- R4: An entry matches when the top plen bits of its MAC equal those of the key. Among the valid matching entries, the one with the largest plen wins, and equal plen goes to the lowest index.
- R5: plen 0 matches every key and serves as a default. plen 48, and any larger value, requires all 48 bits to be equal.
- R6: A frame with fewer than 14 bytes in total is dropped. A frame of exactly 14 bytes is forwarded.
- R7: A frame with s_terr high on any accepted beat, including the first or the last, is dropped.
- R8: A forwarded frame leaves with the same number of beats and the same tdata, tkeep and tlast on each beat. While m_tvalid is high and m_tready is low, the output beat holds steady.
- R9: A table write with tbl_valid = 0 removes the entry from matching.
- R10: Each frame that is not dropped increments either hit_count or miss_count. Each dropped frame increments drop_count. Every counter stops at 2^CNT_W-1.
- R11: A table write affects every frame whose decision is made after the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Input beat accepted |
| s_tdata | input | DATA_W | Input beat data, lane 0 = first byte |
| s_tkeep | input | DATA_W/8 | Input byte enables, packed from lane 0 |
| s_tlast | input | 1 | Last beat of frame |
| s_terr | input | 1 | Error flag for this beat |
| s_meta | input | META_W | Frame metadata, sampled on the first beat |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Output beat accepted |
| m_tdata | output | DATA_W | Output beat data |
| m_tkeep | output | DATA_W/8 | Output byte enables |
| m_tlast | output | 1 | Last output beat |
| m_meta | output | META_W | Metadata with updated egress field |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | log2(ENTRIES) | Entry index to write |
| tbl_valid | input | 1 | Valid bit for the entry |
| tbl_mac | input | 48 | MAC value for the entry |
| tbl_plen | input | 6 | Prefix length in bits |
| tbl_port | input | PORT_W | Destination port for the entry |
| hit_count | output | CNT_W | Saturating count of hit frames |
| miss_count | output | CNT_W | Saturating count of miss frames |
| drop_count | output | CNT_W | Saturating count of dropped frames |

## Verification
A fault in the prefix priority or in the mask arithmetic shows up as a wrong egress field on the very next frame whose address lies between two programmed prefixes. The bench therefore sends frames that fall between overlapping and tied entries. A header byte counter that has gone wrong either drops a legal 14-byte frame or passes a 13-byte one, and the frame after that also reveals it through drop_count. Buffer pointer faults show up as missing, duplicated or reordered beats in the same frame, most visibly under random output stalls. A stuck control state shows up as s_tready staying low, so the next frame never starts.

// File: rtl/mac_lpm_pkg.sv
// Shared constants, state type and prefix-mask helper for the MAC
// prefix forwarding stage. Assumes 48-bit Ethernet addresses.
package mac_lpm_pkg;

    localparam int MAC_W     = 48;
    localparam int PLEN_W    = 6;
    localparam int DA_BYTES  = 6;
    localparam int HDR_BYTES = 14;

    typedef enum logic [1:0] {
        ST_RX     = 2'd0,
        ST_DECIDE = 2'd1,
        ST_DRAIN  = 2'd2
    } fwd_state_e;

    // Mask with the top plen bits set; plen >= MAC_W gives all ones.
    function automatic logic [MAC_W-1:0] prefix_mask(input logic [PLEN_W-1:0] plen);
        logic [MAC_W-1:0] m;
        if (plen == '0)
            m = '0;
        else if (int'(plen) >= MAC_W)
            m = '1;
        else
            m = {MAC_W{1'b1}} << (MAC_W - int'(plen));
        return m;
    endfunction

endpackage

// File: rtl/mac_lpm_table.sv
// Programmable longest-prefix-match table. Holds ENTRIES entries, each
// with a valid bit, MAC value, clamped prefix length and port. The lookup
// is combinational on the current register contents. A write therefore
// becomes visible only from the cycle after the strobe.
module mac_lpm_table
    import mac_lpm_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int PORT_W  = 4,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic [MAC_W-1:0]  wr_mac,
    input  logic [PLEN_W-1:0] wr_plen,
    input  logic [PORT_W-1:0] wr_port,
    input  logic [MAC_W-1:0]  key,
    output logic              lk_hit,
    output logic [PORT_W-1:0] lk_port
);

    logic [ENTRIES-1:0]              ent_valid;
    logic [ENTRIES-1:0][MAC_W-1:0]   ent_mac;
    logic [ENTRIES-1:0][PLEN_W-1:0]  ent_plen;
    logic [ENTRIES-1:0][PORT_W-1:0]  ent_port;
    logic [ENTRIES-1:0]              ent_match;
    logic [ENTRIES-1:0]              ent_default;
    logic [PLEN_W-1:0]               best_len;

    // Entry storage: one register set per entry, written by index.
    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_ent
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ent_valid[g] <= 1'b0;
                    ent_mac[g]   <= '0;
                    ent_plen[g]  <= '0;
                    ent_port[g]  <= '0;
                end else if (wr_en && (int'(wr_idx) == g)) begin
                    ent_valid[g] <= wr_valid;
                    ent_mac[g]   <= wr_mac;
                    ent_plen[g]  <= (int'(wr_plen) > MAC_W) ? PLEN_W'(MAC_W) : wr_plen;
                    ent_port[g]  <= wr_port;
                end
            end
            assign ent_match[g]   = ent_valid[g] &&
                                    (((key ^ ent_mac[g]) & prefix_mask(ent_plen[g])) == '0);
            assign ent_default[g] = ent_valid[g] && (ent_plen[g] == '0);
        end
    endgenerate

    // Priority search: a longer prefix replaces the current best, and equal length keeps the lower index.
    always_comb begin
        lk_hit   = 1'b0;
        lk_port  = '0;
        best_len = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (ent_match[i] && (!lk_hit || (ent_plen[i] > best_len))) begin
                lk_hit   = 1'b1;
                lk_port  = ent_port[i];
                best_len = ent_plen[i];
            end
        end
    end

    // R5: a valid zero-length entry guarantees a hit for any key.
    p_default_hits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|ent_default) |-> lk_hit);

endmodule

// File: rtl/hdr_capture.sv
// Header capture for one frame at a time. Collects destination MAC bytes
// 0..5, a saturating byte count and a sticky error flag, and samples the
// metadata on the first beat. It assumes byte enables packed from lane 0.
// clear rearms it for the next frame.
module hdr_capture
    import mac_lpm_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int META_W  = 16,
    localparam int KEEP_W = DATA_W / 8,
    localparam int BC_W   = $clog2(HDR_BYTES + KEEP_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              beat_en,
    input  logic [DATA_W-1:0] tdata,
    input  logic [KEEP_W-1:0] tkeep,
    input  logic              terr,
    input  logic [META_W-1:0] meta_in,
    output logic [MAC_W-1:0]  da,
    output logic              hdr_ok,
    output logic              err,
    output logic [META_W-1:0] meta
);

    localparam int BC_MAX = (1 << BC_W) - 1;

    logic [BC_W-1:0]  cnt_q;
    logic [BC_W-1:0]  cnt_nxt;
    logic [MAC_W-1:0] da_nxt;
    logic             first_q;

    // Next address bytes and byte count for the beat being accepted.
    always_comb begin
        int pos;
        int sum;
        da_nxt = da;
        for (int k = 0; k < KEEP_W; k++) begin
            pos = int'(cnt_q) + k;
            if (tkeep[k] && (pos < DA_BYTES))
                da_nxt[MAC_W-1-8*pos -: 8] = tdata[8*k +: 8];
        end
        sum     = int'(cnt_q) + $countones(tkeep);
        cnt_nxt = (sum > BC_MAX) ? BC_W'(BC_MAX) : BC_W'(sum);
    end

    // Capture registers, updated on each accepted beat and cleared between frames.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q   <= '0;
            da      <= '0;
            err     <= 1'b0;
            meta    <= '0;
            first_q <= 1'b1;
        end else if (beat_en) begin
            cnt_q   <= cnt_nxt;
            da      <= da_nxt;
            err     <= err | terr;
            first_q <= 1'b0;
            if (first_q)
                meta <= meta_in;
        end
    end

    assign hdr_ok = (int'(cnt_q) >= HDR_BYTES);

    // R7: an error flag, once seen, stays set until the frame is cleared.
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !clear) |=> err);

endmodule

// File: rtl/frame_fifo.sv
// Beat buffer for one frame. It is a plain synchronous FIFO with a
// single-cycle flush that discards everything stored. It assumes the
// writer never pushes while full.
module frame_fifo #(
    parameter int WIDTH   = 73,
    parameter int DEPTH   = 32,
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             full
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W:0]   wptr;
    logic [PTR_W:0]   rptr;

    // Storage write; no reset needed on the data array.
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wptr[PTR_W-1:0]] <= wr_data;
    end

    // Pointer update with flush taking priority over push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (wr_en) wptr <= wptr + 1'b1;
            if (rd_en) rptr <= rptr + 1'b1;
        end
    end

    assign rd_data = mem[rptr[PTR_W-1:0]];
    assign empty   = (wptr == rptr);
    assign full    = (wptr[PTR_W] != rptr[PTR_W]) && (wptr[PTR_W-1:0] == rptr[PTR_W-1:0]);

    // R8: no push into a full buffer and no pop from an empty one.
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full);
    p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty);

endmodule

// File: rtl/mac_lpm_fwd.sv
// Top of the destination-MAC prefix forwarding stage. It takes in one
// frame, decides in a single cycle after its last beat, then drops it by
// flush or sends it with updated metadata. It keeps saturating event
// counters. It assumes frames fit in FIFO_DEPTH beats.
module mac_lpm_fwd
    import mac_lpm_pkg::*;
#(
    parameter int DATA_W     = 64,
    parameter int META_W     = 16,
    parameter int PORT_W     = 4,
    parameter int ENTRIES    = 16,
    parameter int FIFO_DEPTH = 32,
    parameter int CNT_W      = 16,
    localparam int KEEP_W    = DATA_W / 8,
    localparam int IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int FW        = DATA_W + KEEP_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_tvalid,
    output logic              s_tready,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic [KEEP_W-1:0] s_tkeep,
    input  logic              s_tlast,
    input  logic              s_terr,
    input  logic [META_W-1:0] s_meta,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic [DATA_W-1:0] m_tdata,
    output logic [KEEP_W-1:0] m_tkeep,
    output logic              m_tlast,
    output logic [META_W-1:0] m_meta,
    input  logic              tbl_we,
    input  logic [IDX_W-1:0]  tbl_idx,
    input  logic              tbl_valid,
    input  logic [MAC_W-1:0]  tbl_mac,
    input  logic [PLEN_W-1:0] tbl_plen,
    input  logic [PORT_W-1:0] tbl_port,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count,
    output logic [CNT_W-1:0]  drop_count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    fwd_state_e        state;
    logic              in_beat;
    logic              out_beat;
    logic              fifo_empty;
    logic              fifo_full;
    logic              fifo_flush;
    logic [FW-1:0]     fifo_rd;
    logic [MAC_W-1:0]  cap_da;
    logic              cap_hdr_ok;
    logic              cap_err;
    logic [META_W-1:0] cap_meta;
    logic              cap_clear;
    logic              lk_hit;
    logic [PORT_W-1:0] lk_port;
    logic              decide;
    logic              drop;
    logic [META_W-1:0] meta_upd;
    logic [META_W-1:0] meta_q;
    logic [2:0]        ev_inc;
    logic [2:0][CNT_W-1:0] ev_cnt;

    assign in_beat    = s_tvalid && s_tready;
    assign out_beat   = m_tvalid && m_tready;
    assign decide     = (state == ST_DECIDE);
    assign drop       = cap_err || !cap_hdr_ok;
    assign fifo_flush = decide && drop;
    assign cap_clear  = decide;

    hdr_capture #(.DATA_W(DATA_W), .META_W(META_W)) i_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (cap_clear),
        .beat_en (in_beat),
        .tdata   (s_tdata),
        .tkeep   (s_tkeep),
        .terr    (s_terr),
        .meta_in (s_meta),
        .da      (cap_da),
        .hdr_ok  (cap_hdr_ok),
        .err     (cap_err),
        .meta    (cap_meta)
    );

    mac_lpm_table #(.ENTRIES(ENTRIES), .PORT_W(PORT_W)) i_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_we),
        .wr_idx   (tbl_idx),
        .wr_valid (tbl_valid),
        .wr_mac   (tbl_mac),
        .wr_plen  (tbl_plen),
        .wr_port  (tbl_port),
        .key      (cap_da),
        .lk_hit   (lk_hit),
        .lk_port  (lk_port)
    );

    frame_fifo #(.WIDTH(FW), .DEPTH(FIFO_DEPTH)) i_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (fifo_flush),
        .wr_en   (in_beat),
        .wr_data ({s_tlast, s_tkeep, s_tdata}),
        .rd_en   (out_beat),
        .rd_data (fifo_rd),
        .empty   (fifo_empty),
        .full    (fifo_full)
    );

    // Metadata with the egress field overwritten on a table hit.
    always_comb begin
        meta_upd = cap_meta;
        if (lk_hit)
            meta_upd[PORT_W-1:0] = lk_port;
    end

    // Frame sequencing: receive, decide for one cycle, then drain or return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_RX;
            meta_q <= '0;
        end else begin
            case (state)
                ST_RX:     if (in_beat && s_tlast) state <= ST_DECIDE;
                ST_DECIDE: begin
                    meta_q <= meta_upd;
                    state  <= drop ? ST_RX : ST_DRAIN;
                end
                ST_DRAIN:  if (out_beat && m_tlast) state <= ST_RX;
                default:   state <= ST_RX;
            endcase
        end
    end

    assign s_tready = (state == ST_RX) && !fifo_full;
    assign m_tvalid = (state == ST_DRAIN) && !fifo_empty;
    assign {m_tlast, m_tkeep, m_tdata} = fifo_rd;
    assign m_meta   = meta_q;

    // Event strobes in the decision cycle: [0] hit, [1] miss, [2] drop.
    assign ev_inc = {decide && drop, decide && !drop && !lk_hit, decide && !drop && lk_hit};

    // Saturating event counters, one per strobe.
    genvar c;
    generate
        for (c = 0; c < 3; c++) begin : g_cnt
            always_ff @(posedge clk) begin
                if (!rst_n)
                    ev_cnt[c] <= '0;
                else if (ev_inc[c] && (ev_cnt[c] != CNT_MAX))
                    ev_cnt[c] <= ev_cnt[c] + 1'b1;
            end
        end
    endgenerate

    assign hit_count  = ev_cnt[0];
    assign miss_count = ev_cnt[1];
    assign drop_count = ev_cnt[2];

    // R10: at most one counter moves per frame decision.
    p_one_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ev_inc));
    // R10: a saturated counter stays at its maximum.
    p_drop_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_count == CNT_MAX) |=> (drop_count == CNT_MAX));
    // R8: a stalled output beat holds its content.
    p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tkeep) && $stable(m_tlast)));
    // R7: an errored frame leaves nothing in the buffer after its decision.
    p_err_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (decide && cap_err) |=> (fifo_empty && (state == ST_RX)));
    // R8: input and output phases never overlap.
    p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> !s_tready);

endmodule

// File: tb/test_mac_lpm_fwd.sv
// Directed bench for the MAC prefix forwarding stage: one task per scenario.
module test_mac_lpm_fwd;

    localparam int CW   = 4;
    localparam int CMAX = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_tvalid = 1'b0;
    logic        s_tready;
    logic [63:0] s_tdata = '0;
    logic [7:0]  s_tkeep = '0;
    logic        s_tlast = 1'b0;
    logic        s_terr = 1'b0;
    logic [15:0] s_meta = '0;
    logic        m_tvalid;
    logic        m_tready = 1'b1;
    logic [63:0] m_tdata;
    logic [7:0]  m_tkeep;
    logic        m_tlast;
    logic [15:0] m_meta;
    logic        tbl_we = 1'b0;
    logic [3:0]  tbl_idx = '0;
    logic        tbl_valid = 1'b0;
    logic [47:0] tbl_mac = '0;
    logic [5:0]  tbl_plen = '0;
    logic [3:0]  tbl_port = '0;
    logic [CW-1:0] hit_count;
    logic [CW-1:0] miss_count;
    logic [CW-1:0] drop_count;

    int n_chk  = 0;
    int n_fail = 0;
    int e_hit  = 0;
    int e_miss = 0;
    int e_drop = 0;

    always #2 clk = ~clk;

    mac_lpm_fwd #(.CNT_W(CW)) i_mac_lpm_fwd (
        .clk(clk), .rst_n(rst_n),
        .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata), .s_tkeep(s_tkeep),
        .s_tlast(s_tlast), .s_terr(s_terr), .s_meta(s_meta),
        .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata), .m_tkeep(m_tkeep),
        .m_tlast(m_tlast), .m_meta(m_meta),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_valid(tbl_valid), .tbl_mac(tbl_mac),
        .tbl_plen(tbl_plen), .tbl_port(tbl_port),
        .hit_count(hit_count), .miss_count(miss_count), .drop_count(drop_count)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input int idx, input bit v, input logic [47:0] mac, input int plen, input int port);
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = 4'(idx); tbl_valid = v; tbl_mac = mac;
        tbl_plen = 6'(plen); tbl_port = 4'(port);
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    // Send one frame, collect the output, check it and update the counter model.
    task automatic run_frame(input string tag, input int nbytes, input logic [47:0] da,
                             input logic [15:0] meta, input int err_beat, input bit exp_drop,
                             input bit exp_hit, input int port, input bit rnd);
        logic [63:0] ed [32];
        logic [7:0]  ek [32];
        logic [15:0] exp_meta;
        logic [15:0] got_meta;
        logic [63:0] bad_act;
        logic [63:0] bad_exp;
        bit          data_ok;
        bit          done;
        int          nb;
        int          got;
        int          idle;
        nb = (nbytes + 7) / 8;
        for (int b = 0; b < 32; b++) begin ed[b] = '0; ek[b] = '0; end
        for (int i = 0; i < nbytes; i++) begin
            logic [7:0] byt;
            byt = (i < 6) ? da[47-8*i -: 8] : 8'((i * 13 + 5) & 255);
            ed[i/8][8*(i%8) +: 8] = byt;
            ek[i/8][i%8] = 1'b1;
        end
        exp_meta = exp_hit ? {meta[15:4], 4'(port)} : meta;
        for (int b = 0; b < nb; b++) begin
            @(negedge clk);
            s_tvalid = 1'b1; s_tdata = ed[b]; s_tkeep = ek[b];
            s_tlast = (b == nb - 1); s_terr = (b == err_beat); s_meta = meta;
            while (!s_tready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        s_tvalid = 1'b0; s_tlast = 1'b0; s_terr = 1'b0;
        got = 0; idle = 0; done = 0; data_ok = 1; got_meta = '0; bad_act = '0; bad_exp = '0;
        while (!done && idle < 60) begin
            @(negedge clk);
            if (m_tvalid && m_tready) begin
                if (got == 0) got_meta = m_meta;
                if (got < 32 && (m_tdata !== ed[got] || m_tkeep !== ek[got] ||
                                 m_tlast !== (got == nb - 1))) begin
                    if (data_ok) begin bad_act = m_tdata; bad_exp = ed[got]; end
                    data_ok = 0;
                end
                got++;
                idle = 0;
                if (m_tlast) done = 1;
            end else begin
                idle++;
            end
            m_tready = rnd ? 1'($urandom_range(0, 1)) : 1'b1;
        end
        m_tready = 1'b1;
        if (exp_drop) begin
            check(got == 0, {tag, " no output beats"}, 64'(got), 64'd0);
            if (e_drop < CMAX) e_drop++;
        end else begin
            check(got == nb, {tag, " R8 beat count"}, 64'(got), 64'(nb));
            check(data_ok, {tag, " R8 beat content"}, bad_act, bad_exp);
            check(got_meta == exp_meta, {tag, " metadata"}, 64'(got_meta), 64'(exp_meta));
            if (exp_hit) begin if (e_hit < CMAX) e_hit++; end
            else begin if (e_miss < CMAX) e_miss++; end
        end
    endtask

    task automatic check_counters(input string tag);
        check(hit_count == 4'(e_hit), {tag, " R10 hit_count"}, 64'(hit_count), 64'(e_hit));
        check(miss_count == 4'(e_miss), {tag, " R10 miss_count"}, 64'(miss_count), 64'(e_miss));
        check(drop_count == 4'(e_drop), {tag, " R10 drop_count"}, 64'(drop_count), 64'(e_drop));
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(m_tvalid == 1'b0, "R1 m_tvalid after reset", 64'(m_tvalid), 64'd0);
        check(s_tready == 1'b1, "R1 s_tready after reset", 64'(s_tready), 64'd1);
        check_counters("R1 reset");
        run_frame("R1 R3 empty table miss", 60, 48'h0211_2233_4455, 16'hA5C3, -1, 0, 0, 0, 0);
    endtask

    task automatic t_exact;
        wr(2, 1, 48'h0211_2233_4455, 48, 5);
        run_frame("R2 R5 exact hit", 64, 48'h0211_2233_4455, 16'hA5C3, -1, 0, 1, 5, 0);
        run_frame("R3 R5 exact lsb differs", 64, 48'h0211_2233_4454, 16'h1234, -1, 0, 0, 0, 0);
    endtask

    task automatic t_lpm;
        wr(3, 1, 48'h0211_2200_0000, 24, 7);
        wr(5, 1, 48'h0211_2233_0000, 32, 9);
        run_frame("R4 longer prefix", 40, 48'h0211_2233_9988, 16'hFFF0, -1, 0, 1, 9, 0);
        run_frame("R4 shorter prefix only", 40, 48'h0211_2244_0001, 16'h0F0F, -1, 0, 1, 7, 0);
        wr(6, 1, 48'h0211_2233_0000, 32, 11);
        run_frame("R4 tie keeps lower index", 40, 48'h0211_2233_9988, 16'h00F1, -1, 0, 1, 9, 0);
        wr(1, 1, 48'h0211_2233_0000, 32, 12);
        run_frame("R4 R11 tie new lower index", 40, 48'h0211_2233_9988, 16'h00F1, -1, 0, 1, 12, 0);
        run_frame("R4 exact beats prefix", 24, 48'h0211_2233_4455, 16'h7777, -1, 0, 1, 5, 0);
    endtask

    task automatic t_default;
        wr(15, 1, 48'hFFFF_FFFF_FFFF, 0, 3);
        run_frame("R5 zero length default", 30, 48'h0ABB_CCDD_EEFF, 16'h8008, -1, 0, 1, 3, 0);
        wr(15, 0, 48'hFFFF_FFFF_FFFF, 0, 3);
        run_frame("R9 invalidated default", 30, 48'h0ABB_CCDD_EEFF, 16'h8008, -1, 0, 0, 0, 0);
    endtask

    task automatic t_short;
        run_frame("R6 13-byte drop", 13, 48'h0211_2233_9988, 16'h1111, -1, 1, 0, 0, 0);
        run_frame("R6 14-byte pass", 14, 48'h0211_2233_9988, 16'h2222, -1, 0, 1, 12, 0);
        run_frame("R6 8-byte drop", 8, 48'h0211_2233_9988, 16'h3333, -1, 1, 0, 0, 0);
    endtask

    task automatic t_err;
        run_frame("R7 error last beat", 40, 48'h0211_2233_9988, 16'h4444, 4, 1, 0, 0, 0);
        run_frame("R7 error first beat", 40, 48'h0211_2233_9988, 16'h5555, 0, 1, 0, 0, 0);
        run_frame("R7 clean after error", 20, 48'h0211_2244_0001, 16'h6666, -1, 0, 1, 7, 0);
    endtask

    task automatic t_backpressure;
        run_frame("R8 long frame stalled", 200, 48'h0211_2233_9988, 16'h9990, -1, 0, 1, 12, 1);
        run_frame("R8 odd length stalled", 61, 48'h0ABB_CCDD_EEFF, 16'hBEEF, -1, 0, 0, 0, 1);
        check_counters("R10 mid run");
    endtask

    task automatic t_saturate;
        for (int i = 0; i < 16; i++)
            run_frame("R10 R6 drop burst", 9, 48'h0211_2233_9988, 16'h0001, -1, 1, 0, 0, 0);
        check(drop_count == 4'(CMAX), "R10 drop_count saturated", 64'(drop_count), 64'(CMAX));
        check_counters("R10 after saturation");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_exact();
        t_lpm();
        t_default();
        t_short();
        t_err();
        t_backpressure();
        t_saturate();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule